// File: doc/BRIEF.md
# PID Controller with Command Feedforward

This block is a fixed-point PID control-loop engine. A single-cycle sample strobe starts each update. The strobe captures a signed setpoint and a signed measured value. From these the block derives the loop error, a running sum of that error, the sample-to-sample change in the error, and the first and second sample-to-sample changes of the setpoint.

The output is built from a constant offset plus six scaled terms:
- proportional, integral and derivative gains applied to the error quantities;
- three feedforward gains applied to the setpoint, its first difference and its second difference.

A dead zone removes small errors. Each error and difference quantity has its own symmetric limit, and the output has a final limit. A limit value of zero turns that limit off.

To keep area low, one multiplier is shared across all six products, so each update takes a fixed number of cycles. A one-cycle valid pulse marks each fresh output. The integral and the three difference values are driven out continuously so the host can observe them.

Top module: `pid_ff_ctrl`

## Requirements
- R1: The raw error is `cmd - fb`, sign-extended to 48 bits. If the magnitude of the raw error is at most `dead` (unsigned), the error becomes 0. Otherwise `dead` is subtracted from its magnitude, keeping its sign. The result is then limited by `lim_err`.
- R2: Every `lim_*` input is an unsigned 32-bit magnitude. A value of 0 leaves the signal unlimited. A nonzero value L clamps the signal to the range [-L, +L].
- R3: On each accepted sample, `err_int` becomes the 48-bit saturating sum of its old value and the limited error. That sum is then clamped by `lim_int`.
- R4: `err_der` is the limited error minus the previous limited error, clamped by `lim_derr`. `cmd_der` is `cmd` minus the previous `cmd`, clamped by `lim_dcmd`. `cmd_der2` is `cmd_der` minus its previous value, clamped by `lim_ddcmd`. Every history value is 0 after reset or disable. All exports change on the accepting clock edge.
- R5: The output starts from `bias` and adds six products:
  - `kp`·error, `ki`·integral, `kd`·error difference;
  - `kf0`·cmd, `kf1`·`cmd_der`, `kf2`·`cmd_der2`.
  
  Each gain is signed with 16 fractional bits. Each product is arithmetically shifted right by 16 and saturated to 48 bits. The sum is then clamped by `lim_out`.
- R6: A sample is accepted when `smp` and `en` are high and no update is in progress. `y` changes, and `y_vld` pulses high for exactly one cycle, 7 clock edges after the accepting edge. A strobe during an update is ignored.
- R7: While `en` is low, the integral, all history, the exports and `y` are held at 0. `y_vld` stays low, strobes are ignored, and any update in progress is abandoned.
- R8: Every intermediate addition saturates at the signed 48-bit range. The final output saturates to the signed 32-bit range, from 0x80000000 to 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loop enable; low clears the loop state |
| smp | input | 1 | Single-cycle sample strobe |
| cmd | input | 32 | Signed setpoint |
| fb | input | 32 | Signed measured value |
| kp | input | 32 | Proportional gain, Q16.16 |
| ki | input | 32 | Integral gain, Q16.16 |
| kd | input | 32 | Derivative gain, Q16.16 |
| kf0 | input | 32 | Setpoint feedforward gain, Q16.16 |
| kf1 | input | 32 | Setpoint-rate feedforward gain, Q16.16 |
| kf2 | input | 32 | Setpoint-acceleration feedforward gain, Q16.16 |
| bias | input | 32 | Signed constant added to the output |
| dead | input | 32 | Error dead-zone width |
| lim_err | input | 32 | Error limit |
| lim_int | input | 32 | Integral limit |
| lim_derr | input | 32 | Error-difference limit |
| lim_dcmd | input | 32 | Setpoint first-difference limit |
| lim_ddcmd | input | 32 | Setpoint second-difference limit |
| lim_out | input | 32 | Output limit |
| y | output | 32 | Signed control output |
| y_vld | output | 1 | One-cycle pulse marking a new output |
| err_int | output | 48 | Error integral |
| err_der | output | 48 | Error difference |
| cmd_der | output | 48 | Setpoint first difference |
| cmd_der2 | output | 48 | Setpoint second difference |

## Verification
The bench probes several edge cases:
- **Dead zone:** errors exactly at, inside and beyond the edge. A design without the subtraction would jump at the edge.
- **Limits of zero:** a design that treated zero as a real bound would pin every signal at 0.
- **Integral ceiling:** the sum must stop at its limit rather than wrap.
- **Strobe mid-update:** a strobe arriving while the shared multiplier is busy must leave the pending result and the history untouched. A design that restarted would emit a different value or shift its latency.
- **Disable and re-enable:** the first setpoint difference after re-enable must equal the setpoint itself, which proves the history was cleared.
- **Extreme operands:** the largest gain with the widest error must pin the output at the 32-bit maximum instead of wrapping to a negative value.

// File: rtl/pidff_pkg.sv
package pidff_pkg;
    localparam int DW    = 32;          // port word width
    localparam int IW    = 48;          // internal arithmetic width
    localparam int FW    = 16;          // gain fraction bits
    localparam int NTERM = 6;           // products per update
    localparam int PW    = DW + IW;     // raw product width
    localparam int IXW   = $clog2(NTERM);

    typedef logic signed [IW-1:0] wide_t;
    typedef logic signed [DW-1:0] word_t;
    typedef logic        [DW-1:0] mag_t;

    typedef struct packed {
        wide_t cmd;
        wide_t err;
        wide_t integ;
        wide_t derr;
        wide_t dcmd;
        wide_t ddcmd;
    } terms_t;

    typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_FIN} seq_t;

    localparam wide_t WMAX = {1'b0, {(IW-1){1'b1}}};
    localparam wide_t WMIN = {1'b1, {(IW-1){1'b0}}};
    localparam word_t YMAX = {1'b0, {(DW-1){1'b1}}};
    localparam word_t YMIN = {1'b1, {(DW-1){1'b0}}};

    function automatic wide_t to_wide(mag_t m);
        return wide_t'({{(IW-DW){1'b0}}, m});
    endfunction

    function automatic wide_t sat_add(wide_t a, wide_t b);
        logic signed [IW:0] s;
        s = {a[IW-1], a} + {b[IW-1], b};
        if (s[IW] != s[IW-1]) return s[IW] ? WMIN : WMAX;
        return s[IW-1:0];
    endfunction

    function automatic wide_t sat_sub(wide_t a, wide_t b);
        logic signed [IW:0] s;
        s = {a[IW-1], a} - {b[IW-1], b};
        if (s[IW] != s[IW-1]) return s[IW] ? WMIN : WMAX;
        return s[IW-1:0];
    endfunction

    function automatic wide_t clamp(wide_t x, mag_t lim);
        wide_t l;
        l = to_wide(lim);
        if (lim == '0) return x;
        if (x > l)     return l;
        if (x < -l)    return -l;
        return x;
    endfunction

    function automatic wide_t dead_zone(wide_t e, mag_t d);
        wide_t l;
        l = to_wide(d);
        if (e > l)  return e - l;
        if (e < -l) return e + l;
        return '0;
    endfunction

    function automatic wide_t scale(word_t g, wide_t v);
        logic signed [PW-1:0] p;
        logic signed [PW-1:0] sh;
        p  = PW'(g) * PW'(v);
        sh = p >>> FW;
        if (sh[PW-1:IW-1] != {(PW-IW+1){sh[PW-1]}}) return sh[PW-1] ? WMIN : WMAX;
        return sh[IW-1:0];
    endfunction

    function automatic word_t sat_word(wide_t x);
        if (x[IW-1:DW-1] != {(IW-DW+1){x[IW-1]}}) return x[IW-1] ? YMIN : YMAX;
        return x[DW-1:0];
    endfunction
endpackage

// File: rtl/pidff_front.sv
module pidff_front
    import pidff_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   accept,
    input  word_t  cmd,
    input  word_t  fb,
    input  mag_t   dead,
    input  mag_t   lim_err,
    input  mag_t   lim_int,
    input  mag_t   lim_derr,
    input  mag_t   lim_dcmd,
    input  mag_t   lim_ddcmd,
    output terms_t t
);
    wide_t  cmd_w;
    wide_t  err_lim;
    terms_t nxt;

    always_comb begin
        cmd_w     = wide_t'(cmd);
        err_lim   = clamp(dead_zone(cmd_w - wide_t'(fb), dead), lim_err);
        nxt.cmd   = cmd_w;
        nxt.err   = err_lim;
        nxt.integ = clamp(sat_add(t.integ, err_lim), lim_int);
        nxt.derr  = clamp(sat_sub(err_lim, t.err), lim_derr);
        nxt.dcmd  = clamp(sat_sub(cmd_w, t.cmd), lim_dcmd);
        nxt.ddcmd = clamp(sat_sub(nxt.dcmd, t.dcmd), lim_ddcmd);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) t <= '0;
        else if (accept) t <= nxt;
    end
endmodule

// File: rtl/pidff_mac.sv
module pidff_mac
    import pidff_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   start,
    input  terms_t t,
    input  word_t  kp,
    input  word_t  ki,
    input  word_t  kd,
    input  word_t  kf0,
    input  word_t  kf1,
    input  word_t  kf2,
    input  word_t  bias,
    input  mag_t   lim_out,
    output word_t  y,
    output logic   y_vld,
    output logic   busy
);
    seq_t           st;
    logic [IXW-1:0] idx;
    wide_t          acc;
    word_t          g_sel;
    wide_t          v_sel;

    always_comb begin
        case (idx)
            IXW'(0): begin g_sel = kp;  v_sel = t.err;   end
            IXW'(1): begin g_sel = ki;  v_sel = t.integ; end
            IXW'(2): begin g_sel = kd;  v_sel = t.derr;  end
            IXW'(3): begin g_sel = kf0; v_sel = t.cmd;   end
            IXW'(4): begin g_sel = kf1; v_sel = t.dcmd;  end
            IXW'(5): begin g_sel = kf2; v_sel = t.ddcmd; end
            default: begin g_sel = '0;  v_sel = '0;      end
        endcase
    end

    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st    <= ST_IDLE;
            idx   <= '0;
            acc   <= '0;
            y     <= '0;
            y_vld <= 1'b0;
        end else begin
            y_vld <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    acc <= wide_t'(bias);
                    idx <= '0;
                    st  <= ST_MAC;
                end
                ST_MAC: begin
                    acc <= sat_add(acc, scale(g_sel, v_sel));
                    if (idx == IXW'(NTERM-1)) st <= ST_FIN;
                    else idx <= idx + 1'b1;
                end
                ST_FIN: begin
                    y     <= sat_word(clamp(acc, lim_out));
                    y_vld <= 1'b1;
                    st    <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pid_ff_ctrl.sv
module pid_ff_ctrl
    import pidff_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         smp,
    input  logic [31:0]  cmd,
    input  logic [31:0]  fb,
    input  logic [31:0]  kp,
    input  logic [31:0]  ki,
    input  logic [31:0]  kd,
    input  logic [31:0]  kf0,
    input  logic [31:0]  kf1,
    input  logic [31:0]  kf2,
    input  logic [31:0]  bias,
    input  logic [31:0]  dead,
    input  logic [31:0]  lim_err,
    input  logic [31:0]  lim_int,
    input  logic [31:0]  lim_derr,
    input  logic [31:0]  lim_dcmd,
    input  logic [31:0]  lim_ddcmd,
    input  logic [31:0]  lim_out,
    output logic [31:0]  y,
    output logic         y_vld,
    output logic [47:0]  err_int,
    output logic [47:0]  err_der,
    output logic [47:0]  cmd_der,
    output logic [47:0]  cmd_der2
);
    terms_t t;
    logic   busy;
    logic   accept;
    word_t  y_w;

    assign accept = smp && en && !busy;

    pidff_front u_front (
        .clk(clk), .rst(rst), .en(en), .accept(accept),
        .cmd(word_t'(cmd)), .fb(word_t'(fb)), .dead(dead),
        .lim_err(lim_err), .lim_int(lim_int), .lim_derr(lim_derr),
        .lim_dcmd(lim_dcmd), .lim_ddcmd(lim_ddcmd), .t(t)
    );

    pidff_mac u_mac (
        .clk(clk), .rst(rst), .en(en), .start(accept), .t(t),
        .kp(word_t'(kp)), .ki(word_t'(ki)), .kd(word_t'(kd)),
        .kf0(word_t'(kf0)), .kf1(word_t'(kf1)), .kf2(word_t'(kf2)),
        .bias(word_t'(bias)), .lim_out(lim_out),
        .y(y_w), .y_vld(y_vld), .busy(busy)
    );

    assign y        = y_w;
    assign err_int  = t.integ;
    assign err_der  = t.derr;
    assign cmd_der  = t.dcmd;
    assign cmd_der2 = t.ddcmd;
endmodule

// File: rtl/pid_ff_ctrl_chk.sv
module pid_ff_ctrl_chk
    import pidff_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        accept,
    input logic [31:0] y,
    input logic        y_vld,
    input logic [47:0] err_int,
    input logic [47:0] cmd_der,
    input logic [31:0] lim_int,
    input logic [31:0] lim_dcmd,
    input logic [31:0] lim_out
);
    wide_t li, ld, lo, iv, dv, yv;

    always_comb begin
        li = to_wide(lim_int);
        ld = to_wide(lim_dcmd);
        lo = to_wide(lim_out);
        iv = wide_t'(err_int);
        dv = wide_t'(cmd_der);
        yv = wide_t'(word_t'(y));
    end

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (y == '0 && !y_vld && err_int == '0));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        y_vld |=> !y_vld);

    assert_out_limit_R5: assert property (@(posedge clk) disable iff (rst)
        (y_vld && $stable(lim_out) && lim_out != '0 && !lim_out[31]) |-> (yv <= lo && yv >= -lo));

    assert_int_limit_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!$stable(lim_int) || lim_int == '0 || (iv <= li && iv >= -li)));

    assert_dcmd_limit_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!$stable(lim_dcmd) || lim_dcmd == '0 || (dv <= ld && dv >= -ld)));
endmodule

bind pid_ff_ctrl pid_ff_ctrl_chk u_chk (.*);

// File: tb/pid_ff_ctrl_test.sv
module pid_ff_ctrl_test;
    typedef logic signed [127:0] big_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic smp = 1'b0;
    logic signed [31:0] cmd = '0, fb = '0, kp = '0, ki = '0, kd = '0;
    logic signed [31:0] kf0 = '0, kf1 = '0, kf2 = '0, bias = '0;
    logic [31:0] dead = '0, lim_err = '0, lim_int = '0, lim_derr = '0;
    logic [31:0] lim_dcmd = '0, lim_ddcmd = '0, lim_out = '0;
    logic signed [31:0] y;
    logic y_vld;
    logic signed [47:0] err_int, err_der, cmd_der, cmd_der2;

    int nchk = 0;
    int nerr = 0;

    big_t m_pcmd, m_pdc, m_pe, m_ig, m_de, m_y;

    always #4 clk = ~clk;

    pid_ff_ctrl uut (
        .clk(clk), .rst(rst), .en(en), .smp(smp), .cmd(cmd), .fb(fb),
        .kp(kp), .ki(ki), .kd(kd), .kf0(kf0), .kf1(kf1), .kf2(kf2),
        .bias(bias), .dead(dead), .lim_err(lim_err), .lim_int(lim_int),
        .lim_derr(lim_derr), .lim_dcmd(lim_dcmd), .lim_ddcmd(lim_ddcmd),
        .lim_out(lim_out), .y(y), .y_vld(y_vld), .err_int(err_int),
        .err_der(err_der), .cmd_der(cmd_der), .cmd_der2(cmd_der2)
    );

    task automatic chk(input bit ok, input string req, input big_t act, input big_t exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic eqchk(input string req, input big_t act, input big_t exp);
        chk(act == exp, req, act, exp);
    endtask

    function automatic big_t lim(big_t x, logic [31:0] l);
        big_t b;
        b = {96'b0, l};
        if (l == 0) return x;
        if (x > b) return b;
        if (x < -b) return -b;
        return x;
    endfunction

    function automatic big_t satn(big_t x, int bits);
        big_t mx;
        mx = (big_t'(1) <<< (bits - 1)) - 1;
        if (x > mx) return mx;
        if (x < -mx - 1) return -mx - 1;
        return x;
    endfunction

    function automatic big_t prod(logic signed [31:0] g, big_t v);
        big_t gg;
        gg = g;
        return satn((gg * v) >>> 16, 48);
    endfunction

    task automatic model_clear();
        m_pcmd = 0; m_pdc = 0; m_pe = 0; m_ig = 0; m_de = 0;
    endtask

    task automatic model_step(input logic signed [31:0] c, input logic signed [31:0] f);
        big_t e, d, ec, dc, ddc, acc;
        e = big_t'(c) - big_t'(f);
        d = {96'b0, dead};
        if (e > d) e = e - d;
        else if (e < -d) e = e + d;
        else e = 0;
        ec   = lim(e, lim_err);
        dc   = lim(satn(big_t'(c) - m_pcmd, 48), lim_dcmd);
        ddc  = lim(satn(dc - m_pdc, 48), lim_ddcmd);
        m_de = lim(satn(ec - m_pe, 48), lim_derr);
        m_ig = lim(satn(m_ig + ec, 48), lim_int);
        acc = big_t'(bias);
        acc = satn(acc + prod(kp, ec), 48);
        acc = satn(acc + prod(ki, m_ig), 48);
        acc = satn(acc + prod(kd, m_de), 48);
        acc = satn(acc + prod(kf0, big_t'(c)), 48);
        acc = satn(acc + prod(kf1, dc), 48);
        acc = satn(acc + prod(kf2, ddc), 48);
        m_y = satn(lim(acc, lim_out), 32);
        m_pcmd = big_t'(c); m_pdc = ddc + m_pdc; m_pdc = dc; m_pe = ec;
    endtask

    // One sample: strobe, check exports after accept, check latency and output.
    task automatic run_sample(input logic signed [31:0] c, input logic signed [31:0] f,
                              input string req, input bit inject);
        int cnt;
        big_t e_dc, e_ddc;
        big_t prev_pdc;
        @(negedge clk);
        cmd = c; fb = f; smp = 1'b1;
        prev_pdc = m_pdc;
        model_step(c, f);
        e_dc = m_pdc;
        e_ddc = lim(satn(e_dc - prev_pdc, 48), lim_ddcmd);
        @(negedge clk);
        smp = 1'b0;
        cnt = 0;
        eqchk("R3 integral export", err_int, m_ig);
        eqchk("R4 error difference export", err_der, m_de);
        eqchk("R4 setpoint difference export", cmd_der, e_dc);
        eqchk("R4 setpoint second difference export", cmd_der2, e_ddc);
        if (inject) begin
            cmd = c + 32'sd777; smp = 1'b1;
            @(negedge clk);
            smp = 1'b0; cnt = 1;
        end
        while (!y_vld && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        eqchk("R6 latency", cnt, 7);
        eqchk(req, y, m_y);
        if (inject) begin
            eqchk("R6 busy strobe ignored", cmd_der, e_dc);
            @(negedge clk);
            eqchk("R6 valid single pulse", y_vld, 0);
        end
    endtask

    task automatic clear_params();
        kp = 0; ki = 0; kd = 0; kf0 = 0; kf1 = 0; kf2 = 0; bias = 0; dead = 0;
        lim_err = 0; lim_int = 0; lim_derr = 0; lim_dcmd = 0; lim_ddcmd = 0; lim_out = 0;
    endtask

    task automatic t_reset();
        eqchk("R7 reset output", y, 0);
        eqchk("R7 reset valid", y_vld, 0);
        eqchk("R7 reset integral", err_int, 0);
        eqchk("R7 reset setpoint difference", cmd_der, 0);
    endtask

    task automatic t_prop();
        clear_params(); kp = 32'sh0002_0000;
        run_sample(1000, 400, "R5 proportional", 0);
        run_sample(-500, 300, "R5 proportional negative", 0);
        kp = 32'sh0000_8000; bias = 25;
        run_sample(101, 0, "R5 half gain with bias", 0);
    endtask

    task automatic t_deadband();
        clear_params(); kp = 32'sh0001_0000; dead = 100;
        run_sample(50, 0, "R1 inside dead zone", 0);
        run_sample(100, 0, "R1 at dead zone edge", 0);
        eqchk("R1 edge gives zero", y, 0);
        run_sample(150, 0, "R1 beyond dead zone", 0);
        eqchk("R1 reduced by width", y, 50);
        run_sample(0, 150, "R1 negative beyond dead zone", 0);
        eqchk("R1 negative reduced", y, -50);
    endtask

    task automatic t_clamps();
        clear_params(); kp = 32'sh0001_0000; lim_err = 200; lim_out = 150;
        run_sample(500, 0, "R2 error and output limit", 0);
        eqchk("R2 positive limit", y, 150);
        run_sample(-500, 0, "R2 negative limit", 0);
        eqchk("R2 negative limit value", y, -150);
        lim_err = 0; lim_out = 0;
        run_sample(1000000, 0, "R2 zero means unlimited", 0);
        eqchk("R2 unlimited value", y, 1000000);
    endtask

    task automatic t_integral();
        clear_params(); ki = 32'sh0001_0000; lim_int = 250;
        run_sample(100, 0, "R3 integral step 1", 0);
        run_sample(100, 0, "R3 integral step 2", 0);
        run_sample(100, 0, "R3 integral clamped", 0);
        eqchk("R3 integral ceiling", err_int, 250);
    endtask

    task automatic t_ff();
        clear_params();
        kf0 = 32'sh0000_8000; kf1 = 32'sh0001_0000; kf2 = 32'sh0002_0000;
        kd = 32'sh0001_0000; bias = 7; lim_ddcmd = 15; lim_dcmd = 25;
        run_sample(0, 0, "R5 feedforward 0", 0);
        run_sample(10, 0, "R5 feedforward 1", 0);
        run_sample(30, 0, "R4 setpoint difference clamp", 0);
        run_sample(60, 5, "R4 second difference clamp", 0);
        run_sample(80, -5, "R5 feedforward 4", 1);
        run_sample(20, 0, "R5 feedforward 5", 0);
    endtask

    task automatic t_disable();
        clear_params(); ki = 32'sh0001_0000;
        run_sample(100, 0, "R7 build integral 1", 0);
        run_sample(100, 0, "R7 build integral 2", 0);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        eqchk("R7 disabled output", y, 0);
        eqchk("R7 disabled integral", err_int, 0);
        smp = 1'b1; cmd = 555;
        @(negedge clk); smp = 1'b0;
        eqchk("R7 strobe ignored when disabled", cmd_der, 0);
        eqchk("R7 no valid when disabled", y_vld, 0);
        model_clear();
        en = 1'b1;
        run_sample(300, 0, "R7 restart", 0);
        eqchk("R7 history cleared", cmd_der, 300);
    endtask

    task automatic t_sat();
        clear_params(); kp = 32'sh7FFF_FFFF;
        run_sample(32'sh7FFF_FFFF, 32'sh8000_0000, "R8 positive saturation", 0);
        eqchk("R8 positive max", y, 32'sh7FFF_FFFF);
        run_sample(32'sh8000_0000, 32'sh7FFF_FFFF, "R8 negative saturation", 0);
        eqchk("R8 negative min", y, -big_t'(64'sh8000_0000));
    endtask

    initial begin
        #(8 * 200000);
        nchk++; nerr++;
        $display("FAIL watchdog R6 actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0; en = 1'b1;
        @(negedge clk);
        t_reset();
        t_prop();
        t_deadband();
        t_clamps();
        t_integral();
        model_clear();
        @(negedge clk); en = 1'b0; @(negedge clk); en = 1'b1;
        t_ff();
        t_disable();
        t_sat();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule